// File: doc/BRIEF.md
# Run-Time Width Link Slice Serializer

This block moves packets built from 32-bit words across a point-to-point link whose data width is chosen while the chip runs. On the transmit side each word is cut into slices as wide as the link. The slices leave least significant first, two per core clock, because the link moves data on both clock edges. A receiver in the same block rebuilds the 32-bit words from the link, marks the first word of each packet and reports the command field of each packet. The link may carry an optional 64-bit-address prefix word in front of the control word, and the last word of a payload that is not a whole word long is padded with zero bytes.

The link is 32 bits wide on the transmit and on the receive side. Each clock carries two bit times: `tx_bt0` holds the first and `tx_bt1` the second. One valid flag and one packet-start flag per lane go with them. In the normal mode a single lane uses the low bits of the link at the configured width. In split mode the 16 low link bits become two independent 8-bit links, each with its own packet input, framing state and receiver. The width and split settings are taken only when no lane has a word in flight or a packet open, so a packet is never sent at two widths.

Top module: `lss_link`

## Requirements
- R1: `cfg_width` codes 0, 1, 2, 3 and 4 select link widths of 2, 4, 8, 16 and 32 bits, and codes 5 to 7 also select 32 bits. A word then holds `tx_vld` of its lane high for 8, 4, 2, 1 and 1 clock cycles. At 32 bits only `tx_bt0` carries data.
- R2: Slices leave the serializer least significant first. In a word's first cycle `tx_bt0` holds bits [w-1:0] and `tx_bt1` holds bits [2w-1:w], where w is the link width. The following cycles continue upward in the same way.
- R3: `s_ready` of a lane stays low while a word is in flight and rises in that word's last link cycle. A source that keeps `s_valid` high therefore gets back-to-back words with no idle link cycle between them.
- R4: `tx_sop` of a lane is high only in the first link cycle of a packet's first word (the word accepted with `s_sop` high).
- R5: The receiver raises `r_wvld` for one cycle per rebuilt word, in the cycle after the word's last link cycle, with the word on `r_word`. `r_sop` is high with the first word of a packet and low with every other word.
- R6: On a word accepted with `s_eop` high, `s_nbytes` values 1, 2 and 3 keep only that many low bytes and send the upper bytes as zero. The value 0 sends all four bytes. `s_nbytes` has no effect on a word without `s_eop`.
- R7: Width and split settings are sampled only while every lane is idle: no word in flight, no packet opened by `s_sop` and not yet closed by `s_eop`, and no `s_valid` offered. A change requested during a packet applies from the next packet.
- R8: With `cfg_split` low, lane 1 keeps `s_ready[1]` and `tx_vld[1]` low, and lane 0 runs at the configured width. With `cfg_split` high, both lanes run at 8 bits regardless of `cfg_width`: lane 0 on link bits [7:0] and lane 1 on link bits [15:8], each carrying its own packets.
- R9: The command field is bits [5:0] of a packet's first word, and the receiver reports it with a one-cycle `r_cmd_vld` pulse. If that field equals 6'h3E (64-bit address prefix), the receiver reports instead bits [5:0] of the second word, with `r_ext` high.
- R10: After reset no lane drives `tx_vld` or `r_wvld`, `s_ready[0]` is high and `s_ready[1]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; two link bit times per period |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 3 | Requested link width code |
| cfg_split | input | 1 | Requests two independent 8-bit lanes |
| s_valid | input | 2 | Word offered, per lane |
| s_ready | output | 2 | Word taken at this edge, per lane |
| s_data | input | 2x32 | Word to send, per lane |
| s_sop | input | 2 | Word is the first of a packet |
| s_eop | input | 2 | Word is the last of a packet |
| s_nbytes | input | 2x2 | Valid byte count of the last word, 0 meaning four |
| tx_bt0 | output | 32 | Link data, first bit time of the cycle |
| tx_bt1 | output | 32 | Link data, second bit time of the cycle |
| tx_vld | output | 2 | Lane carries a slice pair this cycle |
| tx_sop | output | 2 | First link cycle of a packet, per lane |
| rx_bt0 | input | 32 | Received link data, first bit time |
| rx_bt1 | input | 32 | Received link data, second bit time |
| rx_vld | input | 2 | Received lane valid |
| rx_sop | input | 2 | Received packet start, per lane |
| r_word | output | 2x32 | Rebuilt word, per lane |
| r_wvld | output | 2 | Rebuilt word valid pulse |
| r_sop | output | 2 | Rebuilt word is first of its packet |
| r_cmd | output | 2x6 | Command field of the last reported packet |
| r_cmd_vld | output | 2 | Command report pulse |
| r_ext | output | 2 | Reported command followed an address prefix |

## Verification
The assertions check on every cycle that the ready handshake never opens in the middle of a word and that a started word keeps its lane busy. They also check that the width and split settings never move while any lane is driving the link, that lane 1 stays parked outside split mode, and that the receiver's slice count stays inside a word. Only the bench's scenarios can show the bit order of slices across the two bit times, the per-width cycle counts, the zero padding of short final words and the command decode after a prefix word. They also show that a width change requested in the middle of a packet waits for the packet to end, and that split lanes carry two packets at once without mixing them.

// File: rtl/lss_pkg.sv
package lss_pkg;

    localparam int WORD_W      = 32;
    localparam int CMD_W       = 6;
    localparam int N_LANES     = 2;
    localparam int SPLIT_SHIFT = 8;
    localparam int CNT_W       = 4;
    localparam int NB_W        = 2;
    localparam logic [CMD_W-1:0] CMD_PREFIX = 6'h3E;

    typedef enum logic [2:0] {
        LW2  = 3'd0,
        LW4  = 3'd1,
        LW8  = 3'd2,
        LW16 = 3'd3,
        LW32 = 3'd4
    } lw_e;

    typedef struct packed {
        lw_e  width;
        logic split;
    } cfg_t;

    // Codes beyond the last defined width fall back to the full link.
    function automatic lw_e lw_norm(input logic [2:0] code);
        if (code > 3'd4) begin
            return LW32;
        end
        return lw_e'(code);
    endfunction

    function automatic int unsigned lw_bits(input lw_e w);
        case (w)
            LW2:     return 2;
            LW4:     return 4;
            LW8:     return 8;
            LW16:    return 16;
            default: return 32;
        endcase
    endfunction

    // Core cycles per word: two slices per cycle, one word per cycle at most.
    function automatic logic [CNT_W-1:0] lw_cycles(input lw_e w);
        case (w)
            LW2:     return 4'd8;
            LW4:     return 4'd4;
            LW8:     return 4'd2;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lw_mask(input lw_e w);
        case (w)
            LW2:     return 32'h0000_0003;
            LW4:     return 32'h0000_000F;
            LW8:     return 32'h0000_00FF;
            LW16:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Zero the bytes beyond the valid count on the closing word.
    function automatic logic [WORD_W-1:0] pad_word(input logic [WORD_W-1:0] d,
                                                   input logic              last,
                                                   input logic [NB_W-1:0]   nb);
        logic [WORD_W-1:0] keep;
        if (!last || nb == '0) begin
            return d;
        end
        keep = (32'h1 << {nb, 3'b000}) - 32'h1;
        return d & keep;
    endfunction

endpackage

// File: rtl/lss_tx_lane.sv
module lss_tx_lane
    import lss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  lw_e               width,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [NB_W-1:0]   in_nbytes,
    output logic [WORD_W-1:0] bt0,
    output logic [WORD_W-1:0] bt1,
    output logic              out_vld,
    output logic              out_sop,
    output logic              idle
);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  left;
        logic              busy;
        logic              sop;
        logic              inpkt;
    } tx_st_t;

    tx_st_t            st_d, st_q;
    logic              last;
    logic              accept;
    logic [WORD_W-1:0] mask_w;
    int unsigned       step;

    always_comb begin
        mask_w   = lw_mask(width);
        step     = lw_bits(width);
        last     = st_q.busy && (st_q.left == 4'd1);
        in_ready = en && (!st_q.busy || last);
        accept   = in_valid && in_ready;

        bt0      = st_q.busy ? (st_q.sh & mask_w) : '0;
        bt1      = (st_q.busy && width != LW32) ? ((st_q.sh >> step) & mask_w) : '0;
        out_vld  = st_q.busy;
        out_sop  = st_q.busy && st_q.sop;
        idle     = !st_q.busy && !st_q.inpkt && !(in_valid && en);

        st_d = st_q;
        if (st_q.busy) begin
            st_d.sh   = st_q.sh >> (2 * step);
            st_d.left = st_q.left - 4'd1;
            st_d.sop  = 1'b0;
            st_d.busy = !last;
        end
        if (accept) begin
            st_d.sh    = pad_word(in_data, in_eop, in_nbytes);
            st_d.left  = lw_cycles(width);
            st_d.busy  = 1'b1;
            st_d.sop   = in_sop;
            st_d.inpkt = !in_eop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TX_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.left > 4'd1) |-> !in_ready);                          // R3
    AST_TX_WORD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !last) |=> out_vld);                                          // R3
    AST_TX_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.left != '0 && st_q.left <= lw_cycles(width)));        // R1
    AST_TX_SOP_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_sop) |=> !out_sop);                                        // R4

endmodule

// File: rtl/lss_rx_lane.sv
module lss_rx_lane
    import lss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lw_e               width,
    input  logic [WORD_W-1:0] bt0,
    input  logic [WORD_W-1:0] bt1,
    input  logic              vld,
    input  logic              sop,
    output logic [WORD_W-1:0] word,
    output logic              wvld,
    output logic              wsop,
    output logic [CMD_W-1:0]  cmd,
    output logic              cmd_vld,
    output logic              ext
);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  cyc;
        logic              sop_pend;
        logic              ext_pend;
        logic [WORD_W-1:0] word;
        logic              wvld;
        logic              wsop;
        logic [CMD_W-1:0]  cmd;
        logic              cmd_vld;
        logic              ext;
    } rx_st_t;

    rx_st_t              st_d, st_q;
    logic [WORD_W-1:0]   mask_w;
    logic [WORD_W-1:0]   base;
    logic [WORD_W-1:0]   merged;
    logic [2*WORD_W-1:0] part0, part1;
    logic [CNT_W-1:0]    ncyc;
    logic                this_sop;
    int unsigned         step;
    int unsigned         off0;

    always_comb begin
        mask_w   = lw_mask(width);
        step     = lw_bits(width);
        ncyc     = lw_cycles(width);
        off0     = int'(st_q.cyc) * 2 * step;
        base     = (st_q.cyc == '0) ? '0 : st_q.acc;
        part0    = {{WORD_W{1'b0}}, bt0 & mask_w} << off0;
        part1    = (width == LW32) ? '0 : ({{WORD_W{1'b0}}, bt1 & mask_w} << (off0 + step));
        merged   = base | part0[WORD_W-1:0] | part1[WORD_W-1:0];
        this_sop = (st_q.cyc == '0) ? sop : st_q.sop_pend;

        st_d         = st_q;
        st_d.wvld    = 1'b0;
        st_d.cmd_vld = 1'b0;
        st_d.ext     = 1'b0;
        if (vld) begin
            if (st_q.cyc + 4'd1 == ncyc) begin
                st_d.word     = merged;
                st_d.wvld     = 1'b1;
                st_d.wsop     = this_sop;
                st_d.cyc      = '0;
                st_d.sop_pend = 1'b0;
                if (this_sop) begin
                    if (merged[CMD_W-1:0] == CMD_PREFIX) begin
                        st_d.ext_pend = 1'b1;
                    end else begin
                        st_d.cmd      = merged[CMD_W-1:0];
                        st_d.cmd_vld  = 1'b1;
                        st_d.ext_pend = 1'b0;
                    end
                end else if (st_q.ext_pend) begin
                    st_d.cmd      = merged[CMD_W-1:0];
                    st_d.cmd_vld  = 1'b1;
                    st_d.ext      = 1'b1;
                    st_d.ext_pend = 1'b0;
                end
            end else begin
                st_d.acc      = merged;
                st_d.cyc      = st_q.cyc + 4'd1;
                st_d.sop_pend = this_sop;
            end
        end

        word    = st_q.word;
        wvld    = st_q.wvld;
        wsop    = st_q.wsop;
        cmd     = st_q.cmd;
        cmd_vld = st_q.cmd_vld;
        ext     = st_q.ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RX_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cyc < lw_cycles(width));                                             // R5
    AST_RX_EXT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        ext |-> (!wsop && wvld));                                                 // R9

endmodule

// File: rtl/lss_link.sv
module lss_link
    import lss_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    cfg_width,
    input  logic                          cfg_split,
    input  logic [N_LANES-1:0]            s_valid,
    output logic [N_LANES-1:0]            s_ready,
    input  logic [N_LANES-1:0][WORD_W-1:0] s_data,
    input  logic [N_LANES-1:0]            s_sop,
    input  logic [N_LANES-1:0]            s_eop,
    input  logic [N_LANES-1:0][NB_W-1:0]  s_nbytes,
    output logic [WORD_W-1:0]             tx_bt0,
    output logic [WORD_W-1:0]             tx_bt1,
    output logic [N_LANES-1:0]            tx_vld,
    output logic [N_LANES-1:0]            tx_sop,
    input  logic [WORD_W-1:0]             rx_bt0,
    input  logic [WORD_W-1:0]             rx_bt1,
    input  logic [N_LANES-1:0]            rx_vld,
    input  logic [N_LANES-1:0]            rx_sop,
    output logic [N_LANES-1:0][WORD_W-1:0] r_word,
    output logic [N_LANES-1:0]            r_wvld,
    output logic [N_LANES-1:0]            r_sop,
    output logic [N_LANES-1:0][CMD_W-1:0] r_cmd,
    output logic [N_LANES-1:0]            r_cmd_vld,
    output logic [N_LANES-1:0]            r_ext
);

    cfg_t                          cfg_d, cfg_q;
    logic [N_LANES-1:0]            lane_idle;
    logic [N_LANES-1:0]            lane_en;
    lw_e                           lane_w   [N_LANES];
    logic [N_LANES-1:0][WORD_W-1:0] lane_b0, lane_b1;
    logic [N_LANES-1:0][WORD_W-1:0] lane_r0, lane_r1;

    always_comb begin
        cfg_d = cfg_q;
        if (&lane_idle) begin
            cfg_d.width = lw_norm(cfg_width);
            cfg_d.split = cfg_split;
        end

        lane_w[0]  = cfg_q.split ? LW8 : cfg_q.width;
        lane_w[1]  = LW8;
        lane_en[0] = 1'b1;
        lane_en[1] = cfg_q.split;

        tx_bt0 = lane_b0[0] | (lane_b0[1] << SPLIT_SHIFT);
        tx_bt1 = lane_b1[0] | (lane_b1[1] << SPLIT_SHIFT);

        lane_r0[0] = rx_bt0;
        lane_r1[0] = rx_bt1;
        lane_r0[1] = rx_bt0 >> SPLIT_SHIFT;
        lane_r1[1] = rx_bt1 >> SPLIT_SHIFT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{width: LW32, split: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        lss_tx_lane u_tx (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (lane_en[g]),
            .width     (lane_w[g]),
            .in_valid  (s_valid[g]),
            .in_ready  (s_ready[g]),
            .in_data   (s_data[g]),
            .in_sop    (s_sop[g]),
            .in_eop    (s_eop[g]),
            .in_nbytes (s_nbytes[g]),
            .bt0       (lane_b0[g]),
            .bt1       (lane_b1[g]),
            .out_vld   (tx_vld[g]),
            .out_sop   (tx_sop[g]),
            .idle      (lane_idle[g])
        );

        lss_rx_lane u_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .width   (lane_w[g]),
            .bt0     (lane_r0[g]),
            .bt1     (lane_r1[g]),
            .vld     (rx_vld[g]),
            .sop     (rx_sop[g]),
            .word    (r_word[g]),
            .wvld    (r_wvld[g]),
            .wsop    (r_sop[g]),
            .cmd     (r_cmd[g]),
            .cmd_vld (r_cmd_vld[g]),
            .ext     (r_ext[g])
        );
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld != '0) |=> $stable(cfg_q));                                       // R7
    AST_LANE1_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.split |-> (!s_ready[1] && !tx_vld[1]));                            // R8

endmodule

// File: tb/lss_link_bench.sv
module lss_link_bench;

    localparam int CLK_NS = 10;
    localparam int NV     = 8;
    // {width code[2:0], nbytes[1:0], first word[31:0]}
    localparam logic [36:0] VEC [NV] = '{
        {3'd0, 2'd0, 32'h1234_5678},
        {3'd1, 2'd1, 32'hA5A5_0F0F},
        {3'd2, 2'd2, 32'hDEAD_BEC1},
        {3'd3, 2'd3, 32'h0BAD_F00D},
        {3'd4, 2'd0, 32'hCAFE_0042},
        {3'd7, 2'd1, 32'h8000_0001},
        {3'd2, 2'd0, 32'hFFFF_FF00},
        {3'd0, 2'd3, 32'h0000_0003}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cfg_width = 3'd4;
    logic             cfg_split = 1'b0;
    logic [1:0]       s_valid = '0;
    logic [1:0]       s_ready;
    logic [1:0][31:0] s_data = '0;
    logic [1:0]       s_sop = '0;
    logic [1:0]       s_eop = '0;
    logic [1:0][1:0]  s_nbytes = '0;
    logic [31:0]      tx_bt0, tx_bt1;
    logic [1:0]       tx_vld, tx_sop;
    logic [1:0][31:0] r_word;
    logic [1:0]       r_wvld, r_sop, r_cmd_vld, r_ext;
    logic [1:0][5:0]  r_cmd;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] rxw  [2][256];
    logic        rxs  [2][256];
    int          rxn  [2] = '{0, 0};
    int          vldn [2] = '{0, 0};
    int          sopn [2] = '{0, 0};
    int          cmdn [2] = '{0, 0};
    logic [5:0]  cmdv [2] = '{6'h0, 6'h0};
    logic        extv [2] = '{1'b0, 1'b0};
    int          acc_at [2];

    lss_link u_lss_link (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_split(cfg_split),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sop(s_sop),
        .s_eop(s_eop), .s_nbytes(s_nbytes),
        .tx_bt0(tx_bt0), .tx_bt1(tx_bt1), .tx_vld(tx_vld), .tx_sop(tx_sop),
        .rx_bt0(tx_bt0), .rx_bt1(tx_bt1), .rx_vld(tx_vld), .rx_sop(tx_sop),
        .r_word(r_word), .r_wvld(r_wvld), .r_sop(r_sop), .r_cmd(r_cmd),
        .r_cmd_vld(r_cmd_vld), .r_ext(r_ext)
    );

    always #(CLK_NS / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Observer: logs rebuilt words, command reports and link activity.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < 2; l++) begin
                if (r_wvld[l]) begin
                    rxw[l][rxn[l] % 256] = r_word[l];
                    rxs[l][rxn[l] % 256] = r_sop[l];
                    rxn[l]++;
                end
                if (r_cmd_vld[l]) begin
                    cmdv[l] = r_cmd[l];
                    extv[l] = r_ext[l];
                    cmdn[l]++;
                end
                if (tx_vld[l]) vldn[l]++;
                if (tx_sop[l]) sopn[l]++;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] b_pad(input logic [31:0] d, input logic [1:0] nb);
        if (nb == 2'd0) return d;
        return d & ~(32'hFFFF_FFFF << (8 * int'(nb)));
    endfunction

    function automatic int b_cycles(input logic [2:0] code);
        case (code)
            3'd0: return 8;
            3'd1: return 4;
            3'd2: return 2;
            default: return 1;
        endcase
    endfunction

    // Offer one word; returns at the falling edge just after it is taken.
    task automatic send_word(input int l, input logic [31:0] d, input logic sop,
                             input logic eop, input logic [1:0] nb);
        @(negedge clk);
        s_valid[l]  = 1'b1;
        s_data[l]   = d;
        s_sop[l]    = sop;
        s_eop[l]    = eop;
        s_nbytes[l] = nb;
        while (!s_ready[l]) @(negedge clk);
        @(negedge clk);
        acc_at[l]  = cyc;
        s_valid[l] = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] w, input logic sp);
        @(negedge clk);
        cfg_width = w;
        cfg_split = sp;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int b0, v0, s0, c0, t0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet after reset
        chk("R10", "tx_vld after reset", {30'b0, tx_vld}, 32'h0);
        chk("R10", "r_wvld after reset", {30'b0, r_wvld}, 32'h0);
        chk("R10", "s_ready after reset", {30'b0, s_ready}, 32'h1);

        // Table walk: two-word packets at each width (R1, R4, R5, R6, R9)
        for (int v = 0; v < NV; v++) begin
            logic [2:0]  code;
            logic [1:0]  nb;
            logic [31:0] d;
            code = VEC[v][36:34];
            nb   = VEC[v][33:32];
            d    = VEC[v][31:0];
            set_cfg(code, 1'b0);
            b0 = rxn[0]; v0 = vldn[0]; s0 = sopn[0]; c0 = cmdn[0];
            send_word(0, d, 1'b1, 1'b0, nb);
            send_word(0, ~d, 1'b0, 1'b1, nb);
            repeat (24) @(negedge clk);
            chk("R5", "word count", rxn[0] - b0, 2);
            chk("R6", "unpadded non-last word", rxw[0][b0 % 256], d);
            chk("R6", "padded last word", rxw[0][(b0 + 1) % 256], b_pad(~d, nb));
            chk("R5", "sop flags", {30'b0, rxs[0][b0 % 256], rxs[0][(b0 + 1) % 256]}, 32'h2);
            chk("R1", "link cycles", vldn[0] - v0, 2 * b_cycles(code));
            chk("R4", "sop cycles", sopn[0] - s0, 1);
            chk("R9", "command", {26'b0, cmdv[0]}, {26'b0, d[5:0]});
            chk("R9", "command reports and ext", {(cmdn[0] - c0), 31'b0} | {31'b0, extv[0]}, 32'h8000_0000);
        end

        // R2: slice order within a word, 8-bit link
        set_cfg(3'd2, 1'b0);
        send_word(0, 32'h4433_2211, 1'b1, 1'b1, 2'd0);
        chk("R2", "first bt0", tx_bt0, 32'h11);
        chk("R2", "first bt1", tx_bt1, 32'h22);
        chk("R4", "tx_sop first cycle", {30'b0, tx_sop}, 32'h1);
        @(negedge clk);
        chk("R2", "second bt0", tx_bt0, 32'h33);
        chk("R2", "second bt1", tx_bt1, 32'h44);
        chk("R4", "tx_sop second cycle", {30'b0, tx_sop}, 32'h0);
        repeat (4) @(negedge clk);

        // R2: 2-bit link, value 6 = slices 2 then 1
        set_cfg(3'd0, 1'b0);
        send_word(0, 32'h0000_0006, 1'b1, 1'b1, 2'd0);
        chk("R2", "2-bit bt0", tx_bt0, 32'h2);
        chk("R2", "2-bit bt1", tx_bt1, 32'h1);
        repeat (10) @(negedge clk);

        // R3: back-to-back words at 2 bits, eight cycles apart, no gap
        v0 = vldn[0]; b0 = rxn[0];
        send_word(0, 32'h1111_1111, 1'b1, 1'b0, 2'd0);
        t0 = acc_at[0];
        send_word(0, 32'h2222_2222, 1'b0, 1'b0, 2'd0);
        chk("R3", "accept spacing 1", acc_at[0] - t0, 8);
        t0 = acc_at[0];
        send_word(0, 32'h3333_3333, 1'b0, 1'b1, 2'd0);
        chk("R3", "accept spacing 2", acc_at[0] - t0, 8);
        repeat (12) @(negedge clk);
        chk("R3", "continuous link cycles", vldn[0] - v0, 24);
        chk("R5", "third word", rxw[0][(b0 + 2) % 256], 32'h3333_3333);

        // R7: width change requested inside a packet waits for its end
        set_cfg(3'd2, 1'b0);
        v0 = vldn[0]; b0 = rxn[0];
        send_word(0, 32'hABCD_0101, 1'b1, 1'b0, 2'd0);
        cfg_width = 3'd0;
        repeat (4) @(negedge clk);
        send_word(0, 32'h5A5A_A5A5, 1'b0, 1'b1, 2'd0);
        repeat (6) @(negedge clk);
        chk("R7", "packet kept old width", vldn[0] - v0, 4);
        chk("R7", "second word intact", rxw[0][(b0 + 1) % 256], 32'h5A5A_A5A5);
        v0 = vldn[0];
        send_word(0, 32'h0F0F_0F0F, 1'b1, 1'b1, 2'd0);
        repeat (12) @(negedge clk);
        chk("R7", "next packet new width", vldn[0] - v0, 8);

        // R9: address prefix word, command from second word
        set_cfg(3'd1, 1'b0);
        c0 = cmdn[0]; b0 = rxn[0];
        send_word(0, 32'h0000_007E, 1'b1, 1'b0, 2'd0);
        send_word(0, 32'h0000_0415, 1'b0, 1'b0, 2'd0);
        send_word(0, 32'hFEED_0001, 1'b0, 1'b1, 2'd0);
        repeat (10) @(negedge clk);
        chk("R9", "prefixed command", {26'b0, cmdv[0]}, 32'h15);
        chk("R9", "prefix flag", {31'b0, extv[0]}, 32'h1);
        chk("R9", "one report", cmdn[0] - c0, 1);
        chk("R5", "prefixed packet words", rxn[0] - b0, 3);

        // R8: split lanes run two packets at 8 bits each
        chk("R8", "lane1 ready unsplit", {31'b0, s_ready[1]}, 32'h0);
        set_cfg(3'd0, 1'b1);
        chk("R8", "lane1 ready split", {31'b0, s_ready[1]}, 32'h1);
        b0 = rxn[0]; s0 = rxn[1]; v0 = vldn[0];
        fork
            begin
                send_word(0, 32'h0102_0304, 1'b1, 1'b0, 2'd0);
                send_word(0, 32'h0506_0708, 1'b0, 1'b1, 2'd0);
            end
            begin
                send_word(1, 32'hA1B2_C3D9, 1'b1, 1'b0, 2'd0);
                send_word(1, 32'hE5F6_0718, 1'b0, 1'b1, 2'd2);
            end
        join
        repeat (8) @(negedge clk);
        chk("R8", "lane0 word0", rxw[0][b0 % 256], 32'h0102_0304);
        chk("R8", "lane0 word1", rxw[0][(b0 + 1) % 256], 32'h0506_0708);
        chk("R8", "lane1 word0", rxw[1][s0 % 256], 32'hA1B2_C3D9);
        chk("R8", "lane1 word1 padded", rxw[1][(s0 + 1) % 256], 32'h0000_0718);
        chk("R8", "lane0 at 8 bits", vldn[0] - v0, 4);
        chk("R8", "lane1 command", {26'b0, cmdv[1]}, 32'h19);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule